// File: doc/BRIEF.md
# Passcode Intrusion and Fire Alarm Controller

This block is the security core of a home controller. A 16-bit code arrives with a one-cycle valid strobe and is compared with a stored code. A match opens the door lock for a programmable number of cycles and resets the run of failed attempts. Each mismatch adds one to a failure count. Two misses are tolerated. The third consecutive miss puts the block into a lockout state. In lockout the door alarm, window alarm, red warning light and yellow wrong-code light all turn on and stay on until an explicit clear.

An arm strobe moves the block from disarmed to armed. While armed, an open window raises the window alarm at once, and an open door raises the door alarm unless the lock has just been released. A correct code disarms the block. The stored code can be replaced only while disarmed, through a separate load strobe. Smoke detection runs on its own path. It is independent of the armed state and of the code logic.

Top module: `secAlarmCtrl`

## Requirements
- R1: After reset all six outputs are low, the block is disarmed, no failures are counted, and the stored code equals the RESET_CODE parameter.
- R2: A sampled entry equal to the stored code sets doorUnlock high for exactly UNLOCK_CYCLES cycles, starting on the cycle after the sampling edge, and clears the failure count.
- R3: A sampled entry that differs from the stored code adds one to the failure count. The first and second consecutive misses change none of the alarm or light outputs.
- R4: The third consecutive miss drives doorAlarm, windowAlarm, redLight and yellowLight high on the cycle after its sampling edge, and drops doorUnlock.
- R5: The lockout outputs stay high until alarmClear is sampled high. The cycle after that, the block is disarmed and its door, window, red and yellow outputs are low.
- R6: While in lockout, every code entry is ignored, a correct one included: no unlock pulse and no change to the lockout outputs.
- R7: fireAlert rises on the cycle after smokeDet is sampled high. It then stays high until alarmClear is sampled while smokeDet is low, whatever the armed state, lockout or code entries.
- R8: While armed, windowOpen high drives windowAlarm high in the same cycle, and windowAlarm stays latched after the window closes until alarmClear.
- R9: While armed, with doorUnlock low, doorOpen high latches doorAlarm from the next cycle until alarmClear.
- R10: A correct entry while armed returns the block to disarmed, so a window opening afterwards raises no alarm.
- R11: codeLoad while disarmed replaces the stored code with codeIn. codeLoad while armed is ignored.
- R12: armCmd moves the block from disarmed to armed on the next edge. This happens only when no entry or load is sampled in the same cycle.
- R13: codeIn is sampled only on cycles where codeValid is high. Other values on codeIn have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| codeIn | input | 16 | Entered or new code |
| codeValid | input | 1 | Entry strobe, one cycle per entry |
| codeLoad | input | 1 | Store codeIn as the new code (disarmed only) |
| armCmd | input | 1 | Arm request strobe |
| alarmClear | input | 1 | Clears latched alarms and lockout |
| doorOpen | input | 1 | Door magnetic switch, high when open |
| windowOpen | input | 1 | Window magnetic switch, high when open |
| smokeDet | input | 1 | Smoke detector bit |
| doorUnlock | output | 1 | Door lock release pulse |
| doorAlarm | output | 1 | Door alarm |
| windowAlarm | output | 1 | Window alarm |
| redLight | output | 1 | Red warning light |
| yellowLight | output | 1 | Yellow wrong-code light |
| fireAlert | output | 1 | Fire alert |

## Verification
The assertions check on every cycle that the lockout lights and both alarms rise together, that lockout holds until a clear, and that an unlock pulse never coexists with lockout. They also check that the fire alert follows smoke and holds, and that both lockout and unlock begin only after a sampled entry. The miss count itself, the exact unlock length, and the effect of the armed state cannot be seen by a property on the ports. The bench scenarios show these by comparing every output against a behavioural model. Those scenarios cover the correct entry that resets the count after two misses, code replacement attempted while armed, and an entry made during lockout.

// File: rtl/secAlarmPkg.sv
package secAlarmPkg;

  typedef enum logic [1:0] {
    ST_DISARMED = 2'd0,
    ST_ARMED    = 2'd1,
    ST_LOCKOUT  = 2'd2
  } secState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCode;
    logic compare;
    logic clearAll;
    logic lockout;
    logic armed;
  } dpCtrl_t;

endpackage

// File: rtl/secAlarmControl.sv
module secAlarmControl
  import secAlarmPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    codeValid,
  input  logic    codeLoad,
  input  logic    armCmd,
  input  logic    alarmClear,
  input  logic    codeMatch,
  input  logic    lastChance,
  output dpCtrl_t ctrl
);

  secState_t state, nextState;

  always_comb begin
    ctrl.clearAll = alarmClear;
    ctrl.lockout  = (state == ST_LOCKOUT);
    ctrl.armed    = (state == ST_ARMED);
    ctrl.loadCode = codeLoad && (state == ST_DISARMED) && !alarmClear;
    ctrl.compare  = codeValid && !alarmClear && (state != ST_LOCKOUT) && !ctrl.loadCode;
  end

  always_comb begin
    nextState = state;
    if (alarmClear) begin
      if (state == ST_LOCKOUT) nextState = ST_DISARMED;
    end else if (ctrl.compare) begin
      if (codeMatch)       nextState = ST_DISARMED;
      else if (lastChance) nextState = ST_LOCKOUT;
    end else if (armCmd && (state == ST_DISARMED) && !ctrl.loadCode) begin
      nextState = ST_ARMED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_DISARMED;
    else       state <= nextState;
  end

endmodule

// File: rtl/secAlarmDatapath.sv
module secAlarmDatapath
  import secAlarmPkg::*;
#(
  parameter int          CODE_W        = 16,
  parameter int          MAX_FAILS     = 3,
  parameter int          UNLOCK_CYCLES = 8,
  parameter logic [15:0] RESET_CODE    = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              doorOpen,
  input  logic              windowOpen,
  input  logic              smokeDet,
  output logic              codeMatch,
  output logic              lastChance,
  output logic              doorUnlock,
  output logic              doorAlarm,
  output logic              windowAlarm,
  output logic              redLight,
  output logic              yellowLight,
  output logic              fireAlert
);

  localparam int CNT_W = $clog2(MAX_FAILS + 1);
  localparam int TMR_W = $clog2(UNLOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_FAILS - 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(UNLOCK_CYCLES);

  logic [CODE_W-1:0] storedCode;
  logic [CNT_W-1:0]  failCnt;
  logic [TMR_W-1:0]  unlockTmr;
  logic              doorLatch, winLatch, fireLatch;
  logic              goodEntry, badEntry, tripLock;

  assign codeMatch  = (codeIn == storedCode);
  assign lastChance = (failCnt == LAST_CNT);
  assign goodEntry  = ctrl.compare && codeMatch;
  assign badEntry   = ctrl.compare && !codeMatch;
  assign tripLock   = badEntry && lastChance;

  always_ff @(posedge clk) begin
    if (!rstN)              storedCode <= RESET_CODE[CODE_W-1:0];
    else if (ctrl.loadCode) storedCode <= codeIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                        failCnt <= '0;
    else if (ctrl.clearAll || ctrl.lockout)           failCnt <= '0;
    else if (goodEntry || tripLock)                   failCnt <= '0;
    else if (badEntry)                                failCnt <= failCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                           unlockTmr <= '0;
    else if (ctrl.lockout || tripLock)   unlockTmr <= '0;
    else if (goodEntry)                  unlockTmr <= TMR_LOAD;
    else if (unlockTmr != '0)            unlockTmr <= unlockTmr - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clearAll) begin
      doorLatch <= 1'b0;
      winLatch  <= 1'b0;
    end else if (!ctrl.lockout && ctrl.armed) begin
      if (windowOpen)                      winLatch  <= 1'b1;
      if (doorOpen && (unlockTmr == '0))   doorLatch <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) fireLatch <= 1'b0;
    else       fireLatch <= smokeDet || (fireLatch && !ctrl.clearAll);
  end

  assign doorUnlock  = (unlockTmr != '0);
  assign doorAlarm   = ctrl.lockout || doorLatch;
  assign windowAlarm = ctrl.lockout || winLatch || (ctrl.armed && windowOpen);
  assign redLight    = ctrl.lockout;
  assign yellowLight = ctrl.lockout;
  assign fireAlert   = fireLatch;

endmodule

// File: rtl/secAlarmCtrl.sv
module secAlarmCtrl
  import secAlarmPkg::*;
#(
  parameter int          CODE_W        = 16,
  parameter int          MAX_FAILS     = 3,
  parameter int          UNLOCK_CYCLES = 8,
  parameter logic [15:0] RESET_CODE    = 16'h0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeIn,
  input  logic              codeValid,
  input  logic              codeLoad,
  input  logic              armCmd,
  input  logic              alarmClear,
  input  logic              doorOpen,
  input  logic              windowOpen,
  input  logic              smokeDet,
  output logic              doorUnlock,
  output logic              doorAlarm,
  output logic              windowAlarm,
  output logic              redLight,
  output logic              yellowLight,
  output logic              fireAlert
);

  dpCtrl_t ctrl;
  logic    codeMatch, lastChance;

  secAlarmControl i_control (
    .clk        (clk),
    .rstN       (rstN),
    .codeValid  (codeValid),
    .codeLoad   (codeLoad),
    .armCmd     (armCmd),
    .alarmClear (alarmClear),
    .codeMatch  (codeMatch),
    .lastChance (lastChance),
    .ctrl       (ctrl)
  );

  secAlarmDatapath #(
    .CODE_W        (CODE_W),
    .MAX_FAILS     (MAX_FAILS),
    .UNLOCK_CYCLES (UNLOCK_CYCLES),
    .RESET_CODE    (RESET_CODE)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .codeIn      (codeIn),
    .doorOpen    (doorOpen),
    .windowOpen  (windowOpen),
    .smokeDet    (smokeDet),
    .codeMatch   (codeMatch),
    .lastChance  (lastChance),
    .doorUnlock  (doorUnlock),
    .doorAlarm   (doorAlarm),
    .windowAlarm (windowAlarm),
    .redLight    (redLight),
    .yellowLight (yellowLight),
    .fireAlert   (fireAlert)
  );

endmodule

// File: rtl/secAlarmChecker.sv
module secAlarmChecker (
  input logic clk,
  input logic rstN,
  input logic codeValid,
  input logic smokeDet,
  input logic alarmClear,
  input logic doorUnlock,
  input logic doorAlarm,
  input logic windowAlarm,
  input logic redLight,
  input logic yellowLight,
  input logic fireAlert
);

  // R4
  lockout_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    redLight |-> (yellowLight && doorAlarm && windowAlarm));

  // R4
  lockout_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(redLight) |-> $past(codeValid));

  // R5
  lockout_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (redLight && !alarmClear) |=> redLight);

  // R6
  no_unlock_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(doorUnlock && redLight));

  // R2
  unlock_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doorUnlock) |-> $past(codeValid));

  // R7
  fire_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    smokeDet |=> fireAlert);

  // R7
  fire_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fireAlert && !alarmClear) |=> fireAlert);

endmodule

bind secAlarmCtrl secAlarmChecker i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .codeValid   (codeValid),
  .smokeDet    (smokeDet),
  .alarmClear  (alarmClear),
  .doorUnlock  (doorUnlock),
  .doorAlarm   (doorAlarm),
  .windowAlarm (windowAlarm),
  .redLight    (redLight),
  .yellowLight (yellowLight),
  .fireAlert   (fireAlert)
);

// File: tb/test_secAlarmCtrl.sv
module test_secAlarmCtrl;

  localparam int          PERIOD  = 10;
  localparam int          UNLOCK  = 5;
  localparam logic [15:0] RST_KEY = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] codeIn = '0;
  logic        codeValid = 0, codeLoad = 0, armCmd = 0, alarmClear = 0;
  logic        doorOpen = 0, windowOpen = 0, smokeDet = 0;
  logic        doorUnlock, doorAlarm, windowAlarm, redLight, yellowLight, fireAlert;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  secAlarmCtrl #(.UNLOCK_CYCLES(UNLOCK), .RESET_CODE(RST_KEY)) i_secAlarmCtrl (
    .clk(clk), .rstN(rstN), .codeIn(codeIn), .codeValid(codeValid),
    .codeLoad(codeLoad), .armCmd(armCmd), .alarmClear(alarmClear),
    .doorOpen(doorOpen), .windowOpen(windowOpen), .smokeDet(smokeDet),
    .doorUnlock(doorUnlock), .doorAlarm(doorAlarm), .windowAlarm(windowAlarm),
    .redLight(redLight), .yellowLight(yellowLight), .fireAlert(fireAlert)
  );

  // behavioural reference
  bit          mArmed, mLock, mDoorL, mWinL, mFire;
  logic [15:0] mKey;
  int          mFails, mTimer;

  always @(posedge clk) begin
    if (!rstN) begin
      mArmed = 0; mLock = 0; mDoorL = 0; mWinL = 0; mFire = 0;
      mKey = RST_KEY; mFails = 0; mTimer = 0;
    end else begin
      bit wasArmed;
      int oldTimer;
      wasArmed = mArmed;
      oldTimer = mTimer;
      if (mTimer > 0) mTimer--;
      mFire = smokeDet || (mFire && !alarmClear);
      if (alarmClear) begin
        if (mLock) begin mLock = 0; mArmed = 0; end
        mFails = 0; mDoorL = 0; mWinL = 0;
      end else if (mLock) begin
        mTimer = 0; mFails = 0;
      end else begin
        if (wasArmed && windowOpen) mWinL = 1;
        if (wasArmed && doorOpen && oldTimer == 0) mDoorL = 1;
        if (codeLoad && !mArmed) mKey = codeIn;
        else if (codeValid) begin
          if (codeIn == mKey) begin
            mFails = 0; mTimer = UNLOCK; mArmed = 0;
          end else if (mFails == 2) begin
            mLock = 1; mFails = 0; mArmed = 0; mTimer = 0;
          end else mFails++;
        end else if (armCmd && !mArmed) mArmed = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(doorUnlock == (mTimer > 0), "R2 doorUnlock", doorUnlock, mTimer > 0);
      chk(redLight == mLock, "R4 redLight", redLight, mLock);
      chk(yellowLight == mLock, "R4 yellowLight", yellowLight, mLock);
      chk(doorAlarm == (mLock || mDoorL), "R9 doorAlarm", doorAlarm, mLock || mDoorL);
      chk(windowAlarm == (mLock || mWinL || (mArmed && windowOpen)), "R8 windowAlarm",
          windowAlarm, mLock || mWinL || (mArmed && windowOpen));
      chk(fireAlert == mFire, "R7 fireAlert", fireAlert, mFire);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      codeValid = 0; codeLoad = 0; armCmd = 0; alarmClear = 0;
    end
  endtask

  task automatic enter(input logic [15:0] c);
    codeIn = c; codeValid = 1; tick();
  endtask

  task automatic probe(output logic [5:0] o);
    @(negedge clk); #1;
    o = {doorUnlock, doorAlarm, windowAlarm, redLight, yellowLight, fireAlert};
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [5:0] o;
    int cnt;
    tick(3);
    probe(o);
    chk(o == 6'b0, "R1 outputs after reset", o, 0);
    rstN = 1; #1;
    tick();
    // reset key accepted
    enter(RST_KEY);
    probe(o);
    chk(doorUnlock == 1, "R1 reset key unlocks", doorUnlock, 1);
    tick(UNLOCK + 1);
    // load a new key while disarmed
    codeIn = 16'h1234; codeLoad = 1; tick();
    enter(16'h1234);
    cnt = 0;
    for (int i = 0; i < UNLOCK + 3; i++) begin
      probe(o);
      if (doorUnlock) cnt++;
      tick();
    end
    chk(cnt == UNLOCK, "R2 unlock length", cnt, UNLOCK);
    // wrong code held without strobe
    codeIn = 16'hDEAD; tick(4);
    probe(o);
    chk(yellowLight == 0, "R13 no entry without strobe", yellowLight, 0);
    enter(16'h0001); enter(16'h0002);
    probe(o);
    chk(redLight == 0, "R3 two misses tolerated", redLight, 0);
    enter(16'h1234); tick(UNLOCK + 1);
    enter(16'h0003); enter(16'h0004);
    probe(o);
    chk(redLight == 0, "R3 count restarts after match", redLight, 0);
    enter(16'h0005);
    probe(o);
    chk(o[5:1] == 5'b01111, "R4 third miss lockout", o[5:1], 5'b01111);
    // entries ignored during lockout
    enter(16'h1234);
    tick(3);
    probe(o);
    chk(doorUnlock == 0 && redLight == 1, "R6 entry ignored in lockout", {doorUnlock, redLight}, 1);
    chk(yellowLight == 1, "R5 lockout held", yellowLight, 1);
    alarmClear = 1; tick();
    probe(o);
    chk(o[4:1] == 4'b0, "R5 clear ends lockout", o[4:1], 0);
    // arming and window
    armCmd = 1; tick();
    windowOpen = 1; #1;
    chk(windowAlarm == 1, "R12 armed window same cycle", windowAlarm, 1);
    chk(windowAlarm == 1, "R8 window immediate", windowAlarm, 1);
    tick(); windowOpen = 0; tick(2);
    probe(o);
    chk(windowAlarm == 1, "R8 window latched", windowAlarm, 1);
    alarmClear = 1; tick();
    probe(o);
    chk(windowAlarm == 0, "R8 window cleared", windowAlarm, 0);
    // door intrusion while armed
    doorOpen = 1; tick(); doorOpen = 0; tick();
    probe(o);
    chk(doorAlarm == 1, "R9 door latched", doorAlarm, 1);
    alarmClear = 1; tick();
    // load ignored while armed
    codeIn = 16'hBEEF; codeLoad = 1; tick();
    enter(16'hBEEF);
    probe(o);
    chk(doorUnlock == 0, "R11 load ignored when armed", doorUnlock, 0);
    enter(16'h1234);
    probe(o);
    chk(doorUnlock == 1, "R10 correct code while armed", doorUnlock, 1);
    tick(UNLOCK + 1);
    windowOpen = 1; tick(2);
    probe(o);
    chk(windowAlarm == 0, "R10 disarmed after code", windowAlarm, 0);
    windowOpen = 0;
    // fire path
    armCmd = 1; tick();
    smokeDet = 1; tick(); smokeDet = 0;
    probe(o);
    chk(fireAlert == 1, "R7 fire rises", fireAlert, 1);
    enter(16'h1234); tick(2);
    probe(o);
    chk(fireAlert == 1, "R7 fire not suppressed by code", fireAlert, 1);
    alarmClear = 1; tick();
    probe(o);
    chk(fireAlert == 0, "R7 fire cleared", fireAlert, 0);
    tick(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule